// File: doc/BRIEF.md
# Configurable SPI Character Shift Engine

This block is the master side of a synchronous serial link. A host loads a 16-bit transmit word, picks a character length from 1 to 16 bits, the clock polarity and phase, and which end of the word holds the character, and then pulses a start strobe. The engine asserts the active-low select line and generates the serial clock from a 16-bit reload divider. It shifts the character out most significant bit first while it shifts the same number of bits in. At the end it releases select and presents the received character, right-aligned, together with a one-cycle done pulse.

Two sticky flags report events to the host. The interrupt-pending flag is raised at the end of a character when interrupts are enabled. The overrun flag is raised when a start arrives while a character is still in flight. Each flag is cleared by writing a 1 to its clear bit. The engine is meant to be driven directly by a small control wrapper. It takes its configuration when a character starts, so the wrapper may change the configuration inputs at any time.

Top module: `spi_char_engine`

## Requirements
- R1: The character length is n = cfg_len for cfg_len 1 to 15, and n = 16 when cfg_len is 0; exactly n bits are sent and n bits received.
- R2: With divisor R = max(cfg_reload, 2), every SCLK half period lasts R clock cycles. The done pulse, one cycle wide, appears (2n+1)*R cycles after the cycle in which start was accepted. SCLK never toggles in two consecutive cycles.
- R3: While idle, SCLK rests at the level of cfg_cpol (0 low, 1 high), and the first edge of each character leaves that level.
- R4: With cfg_cpha = 0 the first bit is on MOSI as select asserts, MOSI changes on edges that return SCLK to rest, and MISO is sampled on edges that leave rest. With cfg_cpha = 1, MOSI changes on edges that leave rest and MISO is sampled on edges that return to rest. MOSI never changes except together with an SCLK edge.
- R5: With cfg_msb_just = 0 the character is tx_word[n-1:0]; with cfg_msb_just = 1 it is tx_word[15:16-n]; either way its most significant bit goes first.
- R6: rx_word holds the received character right-aligned (first bit received in bit n-1), bits above n-1 are zero, and it is valid from the done pulse on.
- R7: busy is 1 from the cycle after start is accepted until done, and ss_n is 0 exactly while busy is 1.
- R8: irq_pend is set with the done pulse when cfg_irq_en is 1, stays 0 at completion when cfg_irq_en is 0, and is cleared by flag_clr bit 0; a set in the same cycle wins.
- R9: A start while busy is ignored (the running character is unaffected) and sets ovr_flag, which is cleared by flag_clr bit 1.
- R10: Configuration and tx_word are taken at start; changing them during a character has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 4 | Character length, 0 means 16 |
| cfg_cpol | input | 1 | SCLK rest level |
| cfg_cpha | input | 1 | Phase select |
| cfg_msb_just | input | 1 | Take character from the top end of tx_word |
| cfg_reload | input | 16 | Baud divider reload value |
| cfg_irq_en | input | 1 | Raise irq_pend at completion |
| start | input | 1 | Start strobe |
| tx_word | input | 16 | Transmit word |
| flag_clr | input | 2 | Write-one clear: bit 0 irq_pend, bit 1 ovr_flag |
| miso | input | 1 | Serial data in |
| rx_word | output | 16 | Received character, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Character in progress |
| irq_pend | output | 1 | Sticky interrupt pending |
| ovr_flag | output | 1 | Sticky start-while-busy flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low slave select |

## Verification
The start strobe is accepted at a clock edge. busy and ss_n follow at that same edge, and the first SCLK edge comes R cycles later. The done pulse, rx_word, and the irq_pend update all follow (2n+1)*R cycles after acceptance. The scoreboard monitor samples on the falling clock edge. It stamps the first cycle with busy high, and when done is seen it compares the elapsed count with (2n+1)*R, using the divisor after clamping. A bench slave model responds to SCLK edges as they happen. The flags are read one cycle after the done pulse or the clear strobe that should move them.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } eng_state_e;

    localparam int FLG_IRQ = 0;
    localparam int FLG_OVR = 1;
    localparam int NFLAG   = 2;

    localparam int MIN_RELOAD = 2;

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    import spi_eng_pkg::*;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] rl;
    } baud_s;

    baud_s st_d, st_q;
    logic [DIV_W-1:0] eff_d;

    always_comb begin
        st_d  = st_q;
        eff_d = (reload < DIV_W'(MIN_RELOAD)) ? DIV_W'(MIN_RELOAD) : reload;
        tick  = 1'b0;
        if (restart) begin
            st_d.rl  = eff_d;
            st_d.cnt = eff_d - DIV_W'(1);
        end else if (run) begin
            if (st_q.cnt == '0) begin
                tick     = 1'b1;
                st_d.cnt = st_q.rl - DIV_W'(1);
            end else begin
                st_d.cnt = st_q.cnt - DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, rl: DIV_W'(MIN_RELOAD)};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_msb_just,
    input  logic              miso,
    input  logic              tick,
    output logic              accept,
    output logic              reject,
    output logic              finish,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    output logic              ss_n,
    output logic [DATA_W-1:0] rx_word
);
    import spi_eng_pkg::*;

    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int EDGE_W = CNT_W + 1;

    typedef struct packed {
        eng_state_e         state;
        logic               cpol;
        logic               cpha;
        logic [CNT_W-1:0]   nbits;
        logic [EDGE_W-1:0]  edge_n;
        logic [DATA_W-1:0]  sh;
        logic [DATA_W-1:0]  rx;
        logic [DATA_W-1:0]  rxo;
        logic               sclk;
        logic               ss_n;
        logic               done;
    } core_s;

    core_s st_d, st_q;
    logic [CNT_W-1:0] n_new;
    logic             lead;
    logic             do_sample;
    logic             do_shift;
    logic             last_tick;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        n_new     = (cfg_len == '0) ? CNT_W'(DATA_W) : CNT_W'(cfg_len);
        accept    = start && (st_q.state == ST_IDLE);
        reject    = start && (st_q.state == ST_XFER);
        finish    = 1'b0;
        lead      = ~st_q.edge_n[0];
        last_tick = (st_q.edge_n == {st_q.nbits, 1'b0});
        do_sample = 1'b0;
        do_shift  = 1'b0;

        case (st_q.state)
            ST_IDLE: begin
                st_d.sclk = cfg_cpol;
                st_d.ss_n = 1'b1;
                if (accept) begin
                    st_d.state  = ST_XFER;
                    st_d.ss_n   = 1'b0;
                    st_d.cpol   = cfg_cpol;
                    st_d.cpha   = cfg_cpha;
                    st_d.nbits  = n_new;
                    st_d.edge_n = '0;
                    st_d.rx     = '0;
                    st_d.sh     = cfg_msb_just ? tx_word
                                               : (tx_word << (DATA_W - int'(n_new)));
                end
            end
            default: begin
                if (tick) begin
                    if (last_tick) begin
                        finish     = 1'b1;
                        st_d.state = ST_IDLE;
                        st_d.ss_n  = 1'b1;
                        st_d.done  = 1'b1;
                        st_d.rxo   = st_q.rx;
                        st_d.sclk  = st_q.cpol;
                    end else begin
                        st_d.sclk   = ~st_q.sclk;
                        st_d.edge_n = st_q.edge_n + EDGE_W'(1);
                        do_sample   = (lead != st_q.cpha);
                        do_shift    = st_q.cpha ? (lead && (st_q.edge_n != '0))
                                                : ~lead;
                        if (do_sample) begin
                            st_d.rx = {st_q.rx[DATA_W-2:0], miso};
                        end
                        if (do_shift) begin
                            st_d.sh = {st_q.sh[DATA_W-2:0], 1'b0};
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, cpol: 1'b0, cpha: 1'b0, nbits: '0,
                      edge_n: '0, sh: '0, rx: '0, rxo: '0, sclk: 1'b0,
                      ss_n: 1'b1, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.state == ST_XFER);
    assign done    = st_q.done;
    assign sclk    = st_q.sclk;
    assign ss_n    = st_q.ss_n;
    assign mosi    = busy ? st_q.sh[DATA_W-1] : 1'b0;
    assign rx_word = st_q.rxo;

endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] flags
);
    logic [NF-1:0] flg_d, flg_q;

    generate
        for (genvar i = 0; i < NF; i++) begin : g_flag
            always_comb begin
                flg_d[i] = set[i] | (flg_q[i] & ~clr[i]);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign flags = flg_q;

endmodule

// File: rtl/spi_char_engine.sv
module spi_char_engine #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 16,
    parameter int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_msb_just,
    input  logic [DIV_W-1:0]  cfg_reload,
    input  logic              cfg_irq_en,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [1:0]        flag_clr,
    input  logic              miso,
    output logic [DATA_W-1:0] rx_word,
    output logic              done,
    output logic              busy,
    output logic              irq_pend,
    output logic              ovr_flag,
    output logic              sclk,
    output logic              mosi,
    output logic              ss_n
);
    import spi_eng_pkg::*;

    logic             accept;
    logic             reject;
    logic             finish;
    logic             tick;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_vec;

    spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (busy),
        .reload  (cfg_reload),
        .tick    (tick)
    );

    spi_shift_core #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .tx_word      (tx_word),
        .cfg_len      (cfg_len),
        .cfg_cpol     (cfg_cpol),
        .cfg_cpha     (cfg_cpha),
        .cfg_msb_just (cfg_msb_just),
        .miso         (miso),
        .tick         (tick),
        .accept       (accept),
        .reject       (reject),
        .finish       (finish),
        .busy         (busy),
        .done         (done),
        .sclk         (sclk),
        .mosi         (mosi),
        .ss_n         (ss_n),
        .rx_word      (rx_word)
    );

    always_comb begin
        flag_set          = '0;
        flag_set[FLG_IRQ] = finish & cfg_irq_en;
        flag_set[FLG_OVR] = reject;
    end

    spi_status_flags #(.NF(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flag_vec)
    );

    assign irq_pend = flag_vec[FLG_IRQ];
    assign ovr_flag = flag_vec[FLG_OVR];

endmodule

// File: rtl/spi_char_engine_chk.sv
module spi_char_engine_chk #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 16,
    parameter int LEN_W  = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LEN_W-1:0]  cfg_len,
    input logic              cfg_cpol,
    input logic              cfg_cpha,
    input logic              cfg_msb_just,
    input logic [DIV_W-1:0]  cfg_reload,
    input logic              cfg_irq_en,
    input logic              start,
    input logic [DATA_W-1:0] tx_word,
    input logic [1:0]        flag_clr,
    input logic              miso,
    input logic [DATA_W-1:0] rx_word,
    input logic              done,
    input logic              busy,
    input logic              irq_pend,
    input logic              ovr_flag,
    input logic              sclk,
    input logic              mosi,
    input logic              ss_n
);

    p_sel_low_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n == !busy)
        else $error("select does not track busy");

    p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)))
        else $error("done without a preceding character");

    p_half_period_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(rst_n) && (sclk != $past(sclk))) |=> (sclk == $past(sclk)))
        else $error("SCLK toggled in consecutive cycles");

    p_mosi_moves_with_sclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (mosi != $past(mosi))) |-> (sclk != $past(sclk)))
        else $error("MOSI changed without an SCLK edge");

    p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && $past(rst_n)) |-> (sclk == $past(cfg_cpol)))
        else $error("idle SCLK not at rest level");

    p_irq_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(cfg_irq_en)) |-> irq_pend)
        else $error("irq_pend not raised at completion");

    p_overrun_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ovr_flag)
        else $error("start while busy did not set overrun");

endmodule

bind spi_char_engine spi_char_engine_chk #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/sim_spi_char_engine.sv
module sim_spi_char_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_len = 4'd8;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        cfg_msb_just = 1'b0;
    logic [15:0] cfg_reload = 16'd2;
    logic        cfg_irq_en = 1'b0;
    logic        start = 1'b0;
    logic [15:0] tx_word = '0;
    logic [1:0]  flag_clr = '0;
    logic        miso = 1'b0;
    logic [15:0] rx_word;
    logic        done, busy, irq_pend, ovr_flag, sclk, mosi, ss_n;

    spi_char_engine u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [15:0] rx;
        logic [15:0] ch;
        int          cycles;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   t0 = 0;
    bit   pb = 1'b0;
    bit   finished = 1'b0;

    // slave model state
    logic [15:0] slv_word = '0;
    int          slv_n = 8;
    int          idx = 0;
    logic [31:0] cap = '0;
    bit          slv_cpol = 1'b0;
    bit          slv_cpha = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge ss_n) begin
        cap = '0;
        idx = slv_n - 1;
        if (!slv_cpha && idx >= 0) miso = slv_word[idx];
    end

    always @(sclk) begin
        if (!ss_n) begin
            if (sclk != slv_cpol) begin
                if (!slv_cpha) begin
                    cap = {cap[30:0], mosi};
                end else begin
                    if (idx >= 0 && idx < 16) miso = slv_word[idx];
                    idx = idx - 1;
                end
            end else begin
                if (!slv_cpha) begin
                    idx = idx - 1;
                    if (idx >= 0 && idx < 16) miso = slv_word[idx];
                end else begin
                    cap = {cap[30:0], mosi};
                end
            end
        end
    end

    // monitor: pops expected items when the design reports completion
    always @(negedge clk) begin
        if (busy && !pb) t0 = cyc;
        if (done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rx_word == e.rx, "R6", {e.tag, " rx_word"}, rx_word, e.rx);
                check(cap[15:0] == e.ch && cap[31:16] == '0, "R5",
                      {e.tag, " MOSI character"}, cap, e.ch);
                check((cyc - t0) == e.cycles, "R2", {e.tag, " start-to-done cycles"},
                      cyc - t0, e.cycles);
            end
        end
        pb = busy;
    end

    task automatic xfer(input logic [15:0] tx, input logic [3:0] len, input bit msbj,
                        input bit cpol, input bit cpha, input logic [15:0] rl,
                        input logic [15:0] slv, input bit perturb, input string tag);
        int n, eff, w;
        logic [15:0] mask, ch;
        exp_t e;
        @(negedge clk);
        cfg_len = len; cfg_msb_just = msbj; cfg_cpol = cpol; cfg_cpha = cpha;
        cfg_reload = rl;
        repeat (2) @(negedge clk);
        n    = (len == 0) ? 16 : int'(len);
        eff  = (rl < 2) ? 2 : int'(rl);
        mask = (n == 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
        ch   = msbj ? 16'(tx >> (16 - n)) : (tx & mask);
        slv_word = slv & mask; slv_n = n; slv_cpol = cpol; slv_cpha = cpha;
        e.rx = slv & mask; e.ch = ch; e.cycles = (2 * n + 1) * eff; e.tag = tag;
        sb.push_back(e);
        tx_word = tx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && ss_n == 1'b0, "R7", {tag, " busy/ss_n after start"},
              {busy, ss_n}, 2'b10);
        if (perturb) begin
            tx_word = ~tx; cfg_len = len + 4'd3; cfg_msb_just = ~msbj;
            cfg_cpha = ~cpha; cfg_reload = 16'd7;
        end
        w = 0;
        while (sb.size() != 0 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        if (w >= 20000) check(1'b0, "R2", {tag, " no done"}, 0, 1);
        check(busy == 1'b0 && ss_n == 1'b1, "R7", {tag, " idle after done"},
              {busy, ss_n}, 2'b01);
        cfg_cpol = cpol; cfg_cpha = cpha;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && ss_n == 1 && done == 0 && sclk == 0, "R7", "reset outputs",
              {busy, ss_n, done, sclk}, 4'b0100);
        check(irq_pend == 0 && ovr_flag == 0 && rx_word == 0, "R8", "reset flags",
              {irq_pend, ovr_flag, rx_word}, 0);

        // R3 idle level follows polarity
        cfg_cpol = 1'b1;
        repeat (2) @(negedge clk);
        check(sclk == 1'b1, "R3", "idle high", sclk, 1);
        cfg_cpol = 1'b0;
        repeat (2) @(negedge clk);
        check(sclk == 1'b0, "R3", "idle low", sclk, 0);

        // R1 R4 R5 across modes, lengths and justification
        xfer(16'hA5C3, 4'd8,  1'b0, 1'b0, 1'b0, 16'd2, 16'h005A, 1'b0, "R1 m0 len8 lsb");
        xfer(16'hA5C3, 4'd8,  1'b1, 1'b1, 1'b1, 16'd3, 16'h00C7, 1'b0, "R4 m3 len8 msb");
        xfer(16'h1234, 4'd0,  1'b0, 1'b0, 1'b1, 16'd4, 16'hBEEF, 1'b0, "R1 m1 len16");
        xfer(16'h0001, 4'd1,  1'b0, 1'b1, 1'b0, 16'd2, 16'h0001, 1'b0, "R1 m2 len1 lsb");
        xfer(16'h8000, 4'd1,  1'b1, 1'b0, 1'b0, 16'd2, 16'h0000, 1'b0, "R5 len1 msb");
        xfer(16'hF00D, 4'd15, 1'b1, 1'b0, 1'b1, 16'd0, 16'h6ACE, 1'b0, "R2 reload0 clamp");
        xfer(16'hFFF5, 4'd5,  1'b0, 1'b1, 1'b1, 16'd1, 16'hFFEA, 1'b0, "R6 len5 upper zero");
        check(rx_word[15:5] == '0, "R6", "upper bits zero", rx_word, rx_word & 16'h1F);

        // R10 configuration changes mid-character
        xfer(16'h3C96, 4'd9, 1'b0, 1'b0, 1'b0, 16'd3, 16'h0155, 1'b1, "R10 perturb");

        // R8 interrupt pending
        cfg_irq_en = 1'b1;
        xfer(16'h0055, 4'd8, 1'b0, 1'b0, 1'b0, 16'd2, 16'h00AA, 1'b0, "R8 irq en");
        check(irq_pend == 1'b1, "R8", "irq set on completion", irq_pend, 1);
        @(negedge clk); flag_clr = 2'b01;
        @(negedge clk); flag_clr = 2'b00;
        check(irq_pend == 1'b0, "R8", "irq cleared by write-one", irq_pend, 0);
        cfg_irq_en = 1'b0;
        xfer(16'h0066, 4'd4, 1'b0, 1'b0, 1'b0, 16'd2, 16'h0009, 1'b0, "R8 irq dis");
        check(irq_pend == 1'b0, "R8", "irq stays clear when disabled", irq_pend, 0);

        // R9 start while busy
        fork
            xfer(16'h00C3, 4'd8, 1'b0, 1'b0, 1'b0, 16'd3, 16'h0081, 1'b0, "R9 overrun");
            begin
                repeat (12) @(negedge clk);
                tx_word = 16'hFFFF;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check(ovr_flag == 1'b1, "R9", "overrun flag set", ovr_flag, 1);
            end
        join
        check(ovr_flag == 1'b1, "R9", "overrun sticky", ovr_flag, 1);
        @(negedge clk); flag_clr = 2'b10;
        @(negedge clk); flag_clr = 2'b00;
        check(ovr_flag == 1'b0, "R9", "overrun cleared", ovr_flag, 0);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule